// File: doc/BRIEF.md
# Transmit FIFO with Link-Down Drain Mode

This block is the transmit buffer for a single Ethernet port. An upstream device writes data beats, each beat carrying start-of-packet and end-of-packet markers, and the block hands them in order to a MAC transmit interface through a valid/ready handshake. It also reports a 2-bit fill status of the kind used by SPI4-2 style flow control. The upstream side uses that status to decide how much more data it may send.

Software uses a drain request bit while the port's link is down. The bit is synchronised into the FIFO clock. While drain is active the block holds its storage empty and silently drops every incoming beat. It starts no frame toward the MAC and reports STARVING, so the upstream device can keep emptying its queues. If a frame has been partly sent when drain begins, one closing beat is added that carries an error marker. When the link is down and drain is off, the status reads SATISFIED. Once drain is cleared, the status again follows the real fill level.

Top module: `tx_drain_fifo`

## Requirements
- R1: After reset, txValid is 0 and fifoStatus is STARVING (2'b00), provided aeThresh is greater than 0.
- R2: In normal mode, beats leave in write order with data, txSop and txEop unchanged and txErr at 0. A beat offered with txReady low stays valid with unchanged data on the next cycle.
- R3: When drainReq is held at 1, drain mode is active no later than the second rising clock edge. From then on fifoStatus is STARVING and the stored contents are discarded.
- R4: While drain is active, written beats are dropped and no beat with txSop is offered. After drainReq returns to 0, the FIFO is empty and the next frame sent is one written after the exit.
- R5: With linkUp at 1 and drain off, fifoStatus is SATISFIED (2'b10) when the fill count is at or above afThresh. It is STARVING (2'b00) when the count is below aeThresh, and HUNGRY (2'b01) otherwise. SATISFIED takes priority over the other two.
- R6: With linkUp at 0 and drain off, fifoStatus is SATISFIED. When drain is on, STARVING overrides the link state.
- R7: If drain begins after a frame's txSop beat was accepted and before its txEop beat was accepted, exactly one extra beat is offered, with txEop=1, txErr=1 and txSop=0. After it is accepted nothing more is offered during drain.
- R8: A beat written while the FIFO holds DEPTH beats is dropped. Only the first DEPTH beats are read out.
- R9: fifoStatus never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock |
| rstN | input | 1 | Active-low asynchronous reset |
| drainReq | input | 1 | Software drain request (asynchronous) |
| linkUp | input | 1 | Link state, 1 = up |
| aeThresh | input | $clog2(DEPTH)+1 | Almost-empty threshold in beats |
| afThresh | input | $clog2(DEPTH)+1 | Almost-full threshold in beats |
| wrValid | input | 1 | Write beat strobe |
| wrData | input | DW | Write beat data |
| wrSop | input | 1 | Write beat is first of a frame |
| wrEop | input | 1 | Write beat is last of a frame |
| txReady | input | 1 | MAC accepts the offered beat |
| txValid | output | 1 | Beat offered to the MAC |
| txData | output | DW | Offered beat data |
| txSop | output | 1 | Offered beat starts a frame |
| txEop | output | 1 | Offered beat ends a frame |
| txErr | output | 1 | Offered beat closes an aborted frame |
| fifoStatus | output | 2 | Flow-control status: 00 STARVING, 01 HUNGRY, 10 SATISFIED |

## Verification
Some properties are checked on every cycle: the status never shows the unused code, a drain request held for two edges always gives STARVING, a flushed store reads empty one cycle later, no push is issued into a full store, and an unaccepted normal beat holds steady. Other behaviour only the directed scenarios can show. These are the threshold bands as the fill level climbs, the single error-marked closing beat of a frame cut by drain, the silent loss of beats written during drain, and the requirement that the first frame after exit is new data, not leftovers.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    ST_STARVING  = 2'b00,
    ST_HUNGRY    = 2'b01,
    ST_SATISFIED = 2'b10
  } fifoStat_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCmd_t;
endpackage

// File: rtl/txf_datapath.sv
module txf_datapath
  import txf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoCmd_t      cmd,
  input  logic [DW-1:0] wrData,
  input  logic          wrSop,
  input  logic          wrEop,
  output logic [DW-1:0] headData,
  output logic          headSop,
  output logic          headEop,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int EW = DW + 2;

  logic [EW-1:0] store [DEPTH];
  logic [CW-1:0] wrPtr, rdPtr;
  logic [EW-1:0] headWord;

  initial begin
    if ((1 << AW) != DEPTH) $display("txf_datapath: DEPTH must be a power of two");
  end

  always_ff @(posedge clk) begin
    if (cmd.push) store[wrPtr[AW-1:0]] <= {wrSop, wrEop, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + CW'(1);
      if (cmd.pop)  rdPtr <= rdPtr + CW'(1);
    end
  end

  assign count    = wrPtr - rdPtr;
  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign headWord = store[rdPtr[AW-1:0]];
  assign headSop  = headWord[EW-1];
  assign headEop  = headWord[EW-2];
  assign headData = headWord[DW-1:0];

  a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.flush) |-> empty);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !cmd.push);
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          drainReq,
  input  logic          linkUp,
  input  logic [CW-1:0] aeThresh,
  input  logic [CW-1:0] afThresh,
  input  logic          wrValid,
  input  logic [CW-1:0] count,
  input  logic          empty,
  input  logic          full,
  input  logic [DW-1:0] headData,
  input  logic          headSop,
  input  logic          headEop,
  input  logic          txReady,
  output fifoCmd_t      cmd,
  output logic          txValid,
  output logic [DW-1:0] txData,
  output logic          txSop,
  output logic          txEop,
  output logic          txErr,
  output logic [1:0]    fifoStatus
);
  logic [1:0] drainSync;
  logic       drainActive;
  logic       inFrame;
  logic       abortQ;
  logic       normalBeat;
  fifoStat_e  statNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) drainSync <= '0;
    else       drainSync <= {drainSync[0], drainReq};
  end
  assign drainActive = drainSync[1];

  assign normalBeat = !abortQ && !drainActive && !empty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortQ  <= 1'b0;
      inFrame <= 1'b0;
    end else begin
      if (abortQ && txReady)         abortQ <= 1'b0;
      else if (drainActive && inFrame) abortQ <= 1'b1;

      if (drainActive)                  inFrame <= 1'b0;
      else if (normalBeat && txReady) begin
        if (headEop)      inFrame <= 1'b0;
        else if (headSop) inFrame <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd.flush = drainActive;
    cmd.push  = wrValid && !full && !drainActive;
    cmd.pop   = normalBeat && txReady;
  end

  assign txValid = abortQ || normalBeat;
  assign txData  = abortQ ? '0 : headData;
  assign txSop   = !abortQ && headSop;
  assign txEop   = abortQ || headEop;
  assign txErr   = abortQ;

  always_comb begin
    if (drainActive)           statNow = ST_STARVING;
    else if (!linkUp)          statNow = ST_SATISFIED;
    else if (count >= afThresh) statNow = ST_SATISFIED;
    else if (count < aeThresh) statNow = ST_STARVING;
    else                       statNow = ST_HUNGRY;
  end
  assign fifoStatus = statNow;

  a_r3_drain_starving: assert property (@(posedge clk) disable iff (!rstN)
    ($past(drainReq, 2) && $past(drainReq)) |-> (fifoStatus == ST_STARVING));

  a_r9_no_code3: assert property (@(posedge clk) disable iff (!rstN)
    fifoStatus != 2'b11);

  a_r2_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !txErr && !drainSync[0]) |=> (txValid && $stable(txData)));
endmodule

// File: rtl/tx_drain_fifo.sv
module tx_drain_fifo
  import txf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          drainReq,
  input  logic          linkUp,
  input  logic [CW-1:0] aeThresh,
  input  logic [CW-1:0] afThresh,
  input  logic          wrValid,
  input  logic [DW-1:0] wrData,
  input  logic          wrSop,
  input  logic          wrEop,
  input  logic          txReady,
  output logic          txValid,
  output logic [DW-1:0] txData,
  output logic          txSop,
  output logic          txEop,
  output logic          txErr,
  output logic [1:0]    fifoStatus
);
  fifoCmd_t      cmd;
  logic [DW-1:0] headData;
  logic          headSop, headEop;
  logic [CW-1:0] count;
  logic          empty, full;

  txf_datapath #(.DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .wrData(wrData), .wrSop(wrSop), .wrEop(wrEop),
    .headData(headData), .headSop(headSop), .headEop(headEop),
    .count(count), .empty(empty), .full(full)
  );

  txf_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .drainReq(drainReq), .linkUp(linkUp),
    .aeThresh(aeThresh), .afThresh(afThresh), .wrValid(wrValid),
    .count(count), .empty(empty), .full(full),
    .headData(headData), .headSop(headSop), .headEop(headEop),
    .txReady(txReady), .cmd(cmd),
    .txValid(txValid), .txData(txData), .txSop(txSop), .txEop(txEop),
    .txErr(txErr), .fifoStatus(fifoStatus)
  );
endmodule

// File: tb/sim_tx_drain_fifo.sv
module sim_tx_drain_fifo;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic drainReq = 1'b0, linkUp = 1'b1;
  logic [CW-1:0] aeThresh = CW'(2), afThresh = CW'(6);
  logic wrValid = 1'b0, wrSop = 1'b0, wrEop = 1'b0, txReady = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic txValid, txSop, txEop, txErr;
  logic [DW-1:0] txData;
  logic [1:0] fifoStatus;

  int nTests = 0, nFail = 0, cyc = 0;

  tx_drain_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFail++;
      $display("FAIL watchdog: run hung");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeBeat(logic [DW-1:0] d, logic s, logic e);
    wrValid = 1'b1; wrData = d; wrSop = s; wrEop = e;
    @(negedge clk);
    wrValid = 1'b0; wrSop = 1'b0; wrEop = 1'b0;
  endtask

  task automatic popBeat(output logic v, output logic [DW-1:0] d,
                         output logic s, output logic e, output logic er);
    v = txValid; d = txData; s = txSop; e = txEop; er = txErr;
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 txValid", txValid, 0);
    chk("R1 status", fifoStatus, 2'b00);
  endtask

  task automatic t_thresholds();
    logic v, s, e, er; logic [DW-1:0] d;
    for (int k = 1; k <= 7; k++) begin
      writeBeat(DW'(16'h100 + k), k == 1, k == 7);
      chk($sformatf("R5 status at %0d", k), fifoStatus,
          (k >= 6) ? 2'b10 : (k < 2) ? 2'b00 : 2'b01);
      chk("R9 code", fifoStatus == 2'b11, 0);
    end
    d = txData;
    repeat (3) @(negedge clk);
    chk("R2 hold valid", txValid, 1);
    chk("R2 hold data", txData, d);
    for (int k = 1; k <= 7; k++) begin
      popBeat(v, d, s, e, er);
      chk("R2 valid", v, 1);
      chk("R2 data", d, 16'h100 + k);
      chk("R2 sop", s, k == 1);
      chk("R2 eop", e, k == 7);
      chk("R2 err", er, 0);
    end
    chk("R2 empty after read", txValid, 0);
    chk("R5 empty status", fifoStatus, 2'b00);
  endtask

  task automatic t_full();
    logic v, s, e, er; logic [DW-1:0] d;
    for (int k = 0; k < DEPTH + 2; k++)
      writeBeat(DW'(16'h200 + k), k == 0 || k >= DEPTH, k >= DEPTH - 1);
    for (int k = 0; k < DEPTH; k++) begin
      popBeat(v, d, s, e, er);
      chk("R8 data", d, 16'h200 + k);
    end
    chk("R8 extra dropped", txValid, 0);
  endtask

  task automatic t_link();
    linkUp = 1'b0;
    @(negedge clk);
    chk("R6 link down satisfied", fifoStatus, 2'b10);
    drainReq = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 drain overrides link", fifoStatus, 2'b00);
    drainReq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 after drain link down", fifoStatus, 2'b10);
    linkUp = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_drain();
    logic v, s, e, er; logic [DW-1:0] d;
    for (int k = 0; k < 4; k++) writeBeat(DW'(16'h300 + k), k == 0, k == 3);
    writeBeat(16'h3aa, 1'b1, 1'b1);
    popBeat(v, d, s, e, er);
    popBeat(v, d, s, e, er);
    chk("R2 mid frame data", d, 16'h301);
    drainReq = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 starving in drain", fifoStatus, 2'b00);
    @(negedge clk);
    chk("R7 abort valid", txValid, 1);
    chk("R7 abort eop", txEop, 1);
    chk("R7 abort err", txErr, 1);
    chk("R7 abort sop", txSop, 0);
    popBeat(v, d, s, e, er);
    chk("R7 nothing after abort", txValid, 0);
    for (int k = 0; k < 8; k++) writeBeat(DW'(16'h400 + k), k == 0, k == 7);
    chk("R4 no output in drain", txValid, 0);
    chk("R3 still starving", fifoStatus, 2'b00);
    drainReq = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 empty after exit", txValid, 0);
    chk("R4 status after exit", fifoStatus, 2'b00);
    writeBeat(16'h500, 1'b1, 1'b0);
    writeBeat(16'h501, 1'b0, 1'b1);
    chk("R5 status after exit", fifoStatus, 2'b01);
    popBeat(v, d, s, e, er);
    chk("R4 new frame data", d, 16'h500);
    chk("R4 new frame sop", s, 1);
    popBeat(v, d, s, e, er);
    chk("R4 new frame end", {e, er}, 2'b10);
    chk("R4 drained after new frame", txValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_thresholds();
    t_full();
    t_link();
    t_drain();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule